// File: doc/BRIEF.md
# Programmable Pseudo-Random Noise Generator

This block makes one pseudo-random bit stream for a three-voice sound generator. All three voices share it. The system clock first goes through a fixed divide-by-16 prescaler. A programmable step-rate divider then counts those prescaler ticks. The step rate is a 5-bit value written through a small register write port at address 6. Each time the step-rate divider expires, a 17-bit maximal-length linear feedback shift register advances once. The noise bit is the register's bit 0.

The rate register can be rewritten at any time, and the divider never stalls. A programmed period of zero runs at the same rate as a period of one. If the period is lowered below the count already reached, the next step comes on the very next prescaler tick instead of waiting for the counter to wrap. Mixing the noise into the voices and any analog shaping are handled elsewhere.

Top module: `noise_gen`

## Requirements
- R1: A synchronous reset seeds the shift register to 0x00001, so noise_out is 1. It also clears the prescaler, the step counter and the period register (period 0).
- R2: The prescaler ticks once every 16 clocks. After reset is released, the first tick falls on the 16th rising edge, so the first step at period 0 changes noise_out on that edge and not before.
- R3: When wr_en is high and wr_addr equals 6, wr_data bits 4..0 are loaded as the period. wr_data bits 7..5 have no effect on the rate.
- R4: A write to any address other than 6 leaves the step rate unchanged.
- R5: Each step shifts the 17-bit register one place toward bit 0. The new bit 16 is the XOR of old bits 0 and 3. noise_out is bit 0.
- R6: With period P (1..31) held, a step occurs once every P prescaler ticks, which is every 16*P clocks. When the period is raised, the current count continues up to the new value.
- R7: Period 0 produces exactly the same output sequence and timing as period 1.
- R8: If a write sets the period at or below the number of ticks already counted, the next step occurs at the next prescaler tick.
- R9: The shift register never reaches zero. The output never keeps the same value for more than 17 consecutive steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address; the period lives at 6 |
| wr_data | input | 8 | Register write data; bits 4..0 are the period |
| noise_out | output | 1 | Pseudo-random noise bit |

## Verification
The bench goes after period zero. A design that decoded it literally would either stall the noise forever or wrap to a 32-tick period, and the output would stop matching the period-one sequence. It writes a period with the top data bits set, and it writes to a neighbouring address. A decoder that was too wide or too loose would then step at the wrong rate. It lowers the period mid-count: a divider that compares for equality would run on for a full counter wrap, about 500 clocks, before stepping again. It also raises the period mid-count, checks the exact edge of the first step after reset, and runs a long stretch to confirm the register never locks up and its output keeps changing.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int LFSR_W     = 17;
    localparam int FB_TAP     = 3;
    localparam int PRE_DIV    = 16;
    localparam int PER_W      = 5;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int NOISE_ADDR = 6;
    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic tick;
        logic step;
    } noise_evt_t;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[0] ^ s[FB_TAP], s[LFSR_W-1:1]};
    endfunction
endpackage

// File: rtl/noise_prescaler.sv
module noise_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/noise_rate_div.sv
module noise_rate_div
    import noise_pkg::*;
#(
    parameter int W      = PER_W,
    parameter int ADDR   = NOISE_ADDR
) (
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr,
    input  logic    tick,
    output logic    step,
    output logic [W-1:0] period_q
);
    localparam int XW = W + 1;

    logic [W-1:0]  cnt_q;
    logic [W-1:0]  eff_period;
    logic [XW-1:0] next_cnt;
    logic          expire;

    // zero behaves as one so the divider can never stall
    assign eff_period = (period_q == '0) ? W'(1) : period_q;
    assign next_cnt   = {1'b0, cnt_q} + XW'(1);
    // ">=" lets a lowered period take effect at the next tick
    assign expire     = (next_cnt >= {1'b0, eff_period});
    assign step       = tick && expire;

    always_ff @(posedge clk) begin
        if (rst)
            period_q <= '0;
        else if (wr.en && (wr.addr == ADDR_W'(ADDR)))
            period_q <= wr.data[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (tick)  cnt_q <= expire ? '0 : next_cnt[W-1:0];
    end
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [LFSR_W-1:0] state_q
);
    always_ff @(posedge clk) begin
        if (rst)          state_q <= LFSR_SEED;
        else if (advance) state_q <= lfsr_next(state_q);
    end
endmodule

// File: rtl/noise_gen.sv
module noise_gen
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              noise_out
);
    reg_wr_t           wr_req;
    noise_evt_t        evt;
    logic [PER_W-1:0]  period_q;
    logic [LFSR_W-1:0] lfsr_q;

    assign wr_req = '{en: wr_en, addr: wr_addr, data: wr_data};

    noise_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (evt.tick)
    );

    noise_rate_div #(.W(PER_W), .ADDR(NOISE_ADDR)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_req),
        .tick     (evt.tick),
        .step     (evt.step),
        .period_q (period_q)
    );

    noise_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .advance (evt.step),
        .state_q (lfsr_q)
    );

    assign noise_out = lfsr_q[0];
endmodule

// File: rtl/noise_gen_chk.sv
module noise_gen_chk
    import noise_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              noise_out,
    input logic [LFSR_W-1:0] lfsr_q,
    input logic              tick,
    input logic              step,
    input logic [PER_W-1:0]  period_q
);
    assert_reset_seed_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lfsr_q == LFSR_SEED && noise_out));

    assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_period_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(NOISE_ADDR)) |=> period_q == $past(wr_data[PER_W-1:0]));

    assert_period_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(wr_en) && $past(wr_addr) == ADDR_W'(NOISE_ADDR))) |-> $stable(period_q));

    assert_shift_rule_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(step)) |-> lfsr_q == {$past(lfsr_q[0]) ^ $past(lfsr_q[FB_TAP]), $past(lfsr_q[LFSR_W-1:1])});

    assert_hold_no_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(step)) |-> $stable(lfsr_q));

    assert_step_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
        step |-> tick);

    assert_never_zero_R9: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

bind noise_gen noise_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .noise_out (noise_out),
    .lfsr_q    (lfsr_q),
    .tick      (evt.tick),
    .step      (evt.step),
    .period_q  (period_q)
);

// File: tb/tb_noise_gen.sv
module tb_noise_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       noise_out;

    int n_checks = 0;
    int n_fail   = 0;
    int e_cnt    = 0;
    int bad      = 0;
    int runlen   = 0;
    int maxrun   = 0;
    logic [16:0] m = 17'h1;
    logic prev_out = 1'b1;
    bit   done = 1'b0;

    noise_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .noise_out(noise_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R5 model: shift toward bit 0, new bit 16 = bit0 ^ bit3
    function automatic logic [16:0] nxt(input logic [16:0] x);
        return {x[0] ^ x[3], x[16:1]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_cnt = 0; m = 17'h1; bad = 0; runlen = 1; maxrun = 1; prev_out = 1'b1;
    endtask

    // called at a negedge; the write is captured on the next edge (never a step edge)
    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        e_cnt++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // advance to edge last_e, steps at first_s + k*ival, compare every cycle
    task automatic run_steps(input int first_s, input int ival, input int last_e, input string tag);
        while (e_cnt < last_e) begin
            bit stepped;
            @(posedge clk);
            e_cnt++;
            stepped = (e_cnt >= first_s) && ((e_cnt - first_s) % ival == 0);
            if (stepped) m = nxt(m);
            @(negedge clk);
            if (noise_out !== m[0]) begin
                if (bad == 0)
                    $display("FAIL %s: noise_out=%0b expected %0b at edge %0d",
                             tag, noise_out, m[0], e_cnt);
                bad++;
            end
            if (stepped) begin
                if (noise_out == prev_out) runlen++;
                else runlen = 1;
                if (runlen > maxrun) maxrun = runlen;
                prev_out = noise_out;
            end
        end
    endtask

    task automatic finish_scn(input string tag);
        n_checks++;
        if (bad != 0) n_fail++;
        bad = 0;
    endtask

    task automatic t_reset_and_first_step();
        do_reset();
        check(noise_out === 1'b1, "R1 reset output", noise_out, 1);
        run_steps(16, 16, 15, "R2 before first tick");
        check(noise_out === 1'b1, "R2 no step before edge 16", noise_out, 1);
        run_steps(16, 16, 16, "R2 first tick");
        check(noise_out === 1'b0, "R2 step at edge 16", noise_out, 0);
        finish_scn("R2");
    endtask

    task automatic t_rate(input logic [7:0] d, input int eff, input int nsteps, input string tag);
        do_reset();
        do_write(4'd6, d);
        run_steps(16*eff, 16*eff, 16*eff*nsteps, tag);
        finish_scn(tag);
    endtask

    task automatic t_other_addr();
        do_reset();
        do_write(4'd5, 8'h03);
        run_steps(16, 16, 16*40, "R4 write to address 5 ignored");
        finish_scn("R4");
    endtask

    task automatic t_lower();
        do_reset();
        do_write(4'd6, 8'd31);
        run_steps(496, 496, 658, "R8 pre-lower");
        do_write(4'd6, 8'd2);
        run_steps(672, 32, 672 + 32*40, "R8 lowered period steps at next tick");
        finish_scn("R8");
    endtask

    task automatic t_raise();
        do_reset();
        do_write(4'd6, 8'd2);
        run_steps(32, 32, 32, "R6 pre-raise");
        do_write(4'd6, 8'd5);
        run_steps(112, 80, 112 + 80*15, "R6 raised period continues count");
        finish_scn("R6");
    endtask

    task automatic t_midrun_reset();
        do_reset();
        do_write(4'd6, 8'd0);
        run_steps(16, 16, 100, "R1 pre-reset run");
        bad = 0;
        do_reset();
        check(noise_out === 1'b1, "R1 mid-run reset reseeds", noise_out, 1);
    endtask

    task automatic t_no_stall();
        do_reset();
        run_steps(16, 16, 16*2000, "R9 long run at period 0");
        finish_scn("R9");
        check(maxrun <= 17, "R9 longest constant run", maxrun, 17);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_and_first_step();
        t_rate(8'h00, 1, 60, "R7 period 0 acts as 1");
        t_rate(8'h01, 1, 60, "R7 period 1");
        t_rate(8'h02, 2, 40, "R6 period 2");
        t_rate(8'h1F, 31, 20, "R6 period 31");
        t_rate(8'hE5, 5, 30, "R3 upper data bits ignored");
        t_other_addr();
        t_lower();
        t_raise();
        t_midrun_reset();
        t_no_stall();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule